// File: doc/BRIEF.md
# Bus Bridge Error-Freeze Gate

This block sits between a host-side memory-mapped port and a device-side port. It also sits on the device's DMA path into system memory. In normal operation it forwards host reads and writes to the device, one transaction at a time. It passes device DMA writes to memory when the target page lies inside one of a small set of programmed windows.

Either of two faults makes the gate freeze and isolate the device. The first is a parity mismatch on any 32-bit data word. The second is a DMA aimed at a page that no enabled window covers. While frozen:

- every host read toward the device completes with all-ones data;
- every host write toward the device is acknowledged and thrown away;
- every DMA request is consumed without reaching memory.

The freeze raises no interrupt. Software finds it only by polling a status word. That word, the window table and a clear control all live in a local register space that stays reachable while frozen.

Top module: `iso_gate`

## Requirements
- R1: After reset, the gate is not frozen, the status word reads 0, and h_rsp_valid, d_req_valid and mem_valid are low.
- R2: When not frozen, a host access whose address top nibble is not 4'hF is passed to the device port. A read returns the device's data. A write's response carries data 0.
- R3: Parity is even: a word is good when the XOR of its 32 data bits equals its parity bit. A host write with bad parity is not passed on, is acknowledged and freezes the gate with cause 0. A device read response with bad parity returns 32'hFFFFFFFF to the host and freezes with cause 0. A mapped DMA with bad parity is not passed to memory and freezes with cause 0. In every case the failing address is recorded.
- R4: A DMA whose page (address bits 31:12) falls in no enabled window is consumed without reaching memory. It freezes the gate with cause 1 and records its address.
- R5: While frozen, a host read toward the device completes with 32'hFFFFFFFF and makes no device request. So does a read that was waiting on the device when the freeze arrived.
- R6: While frozen, a host write toward the device is acknowledged (response data 0) and makes no device request.
- R7: While frozen, every DMA request is accepted and none reaches memory.
- R8: Local registers sit at addresses with top nibble 4'hF, selected by address bits 7:2. They are reachable whether frozen or not. The layout is:
  - offset 0x00: status, with bit 0 frozen, bit 1 cause (0 parity, 1 unmapped DMA) and bit 2 overflow;
  - offset 0x04: failing address;
  - offset 0x08: control;
  - offset 0x10+8*i: window base i;
  - offset 0x14+8*i: window limit i.
- R9: A good-parity write of 1 in bit 0 of the control register clears frozen, cause, overflow and the failing address. The next host access is forwarded normally.
- R10: An error detected while already frozen leaves the recorded cause and address unchanged and sets the sticky overflow bit.
- R11: A host response stays valid with unchanged data until h_rsp_ready is high.
- R12: The table has 4 windows:
  - a base register holds the enable in bit 31 and the first page in bits 19:0;
  - a limit register holds the last page in bits 19:0, inclusive;
  - a disabled window matches nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_req_valid | input | 1 | Host request valid |
| h_req_ready | output | 1 | Gate can take a host request |
| h_req_write | input | 1 | 1 = write, 0 = read |
| h_req_addr | input | 32 | Host byte address |
| h_req_wdata | input | 32 | Host write data |
| h_req_wpar | input | 1 | Even parity bit of h_req_wdata |
| h_rsp_valid | output | 1 | Host response valid |
| h_rsp_ready | input | 1 | Host takes the response |
| h_rsp_rdata | output | 32 | Read data, 0 for writes |
| d_req_valid | output | 1 | Device request valid |
| d_req_ready | input | 1 | Device takes the request |
| d_req_write | output | 1 | Device request direction |
| d_req_addr | output | 32 | Device request address |
| d_req_wdata | output | 32 | Device write data |
| d_rsp_valid | input | 1 | Device response valid |
| d_rsp_ready | output | 1 | Gate takes the device response |
| d_rsp_rdata | input | 32 | Device read data |
| d_rsp_rpar | input | 1 | Even parity bit of d_rsp_rdata |
| dma_valid | input | 1 | DMA write request valid |
| dma_ready | output | 1 | DMA request consumed |
| dma_addr | input | 32 | DMA target address |
| dma_data | input | 32 | DMA write data |
| dma_par | input | 1 | Even parity bit of dma_data |
| mem_valid | output | 1 | Memory write valid |
| mem_ready | input | 1 | Memory takes the write |
| mem_addr | output | 32 | Memory write address |
| mem_data | output | 32 | Memory write data |

## Verification
A local or frozen host access has its response valid one cycle after the request handshake. A forwarded access presents its device request in the cycle after acceptance and returns its response one cycle after the device response is taken. DMA gating is combinational, so mem_valid and dma_ready follow the same-cycle request. A freeze or clear takes effect at the edge of the handshake that caused it.

Every bench task drives and samples on the falling edge. Each task waits on ready or valid rather than counting fixed delays. Status is read back only through a later host transaction, so the result is checked after the state has settled. Device and memory traffic are counted by bench models, which shows whether anything slipped through while the gate was frozen.

// File: rtl/iso_pkg.sv
package iso_pkg;

    localparam int IG_AW = 32;
    localparam int IG_DW = 32;

    localparam logic [3:0]       LOCAL_TAG = 4'hF;
    localparam logic [5:0]       OFF_STAT  = 6'd0;
    localparam logic [5:0]       OFF_EADDR = 6'd1;
    localparam logic [5:0]       OFF_CTRL  = 6'd2;
    localparam logic [5:0]       OFF_WIN   = 6'd4;
    localparam logic [IG_DW-1:0] ALL_ONES  = '1;

    typedef enum logic [1:0] {
        HS_IDLE,
        HS_DEVREQ,
        HS_DEVRSP,
        HS_RESP
    } host_st_e;

    typedef enum logic {
        CAUSE_PARITY   = 1'b0,
        CAUSE_UNMAPPED = 1'b1
    } cause_e;

    // bit 2 overflow, bit 1 cause, bit 0 frozen
    typedef struct packed {
        logic   ovf;
        cause_e cause;
        logic   frozen;
    } stat_t;

    typedef struct packed {
        logic             write;
        logic [IG_AW-1:0] addr;
        logic [IG_DW-1:0] data;
    } hreq_t;

    function automatic logic par_bad(input logic [IG_DW-1:0] d, input logic p);
        return (^d) != p;
    endfunction

endpackage

// File: rtl/iso_win_table.sv
module iso_win_table
    import iso_pkg::*;
#(
    parameter int N_WIN     = 4,
    parameter int PAGE_BITS = 12,
    localparam int PG_W     = IG_AW - PAGE_BITS,
    localparam int IDX_W    = (N_WIN > 1) ? $clog2(N_WIN) : 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        we,
    input  logic [IDX_W-1:0]            idx,
    input  logic                        is_lim,
    input  logic                        wvld,
    input  logic [PG_W-1:0]             wpage,
    input  logic [PG_W-1:0]             chk_page,
    output logic                        hit,
    output logic [N_WIN-1:0][IG_DW-1:0] rd_base,
    output logic [N_WIN-1:0][IG_DW-1:0] rd_lim
);

    logic [N_WIN-1:0] hits;

    for (genvar i = 0; i < N_WIN; i++) begin : g_win
        logic            vld_q;
        logic [PG_W-1:0] base_q;
        logic [PG_W-1:0] lim_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                vld_q  <= 1'b0;
                base_q <= '0;
                lim_q  <= '0;
            end else if (we && idx == IDX_W'(i)) begin
                if (is_lim) begin
                    lim_q <= wpage;
                end else begin
                    base_q <= wpage;
                    vld_q  <= wvld;
                end
            end
        end

        assign hits[i]    = vld_q && (chk_page >= base_q) && (chk_page <= lim_q);
        assign rd_base[i] = {vld_q, {(IG_DW-1-PG_W){1'b0}}, base_q};
        assign rd_lim[i]  = {{(IG_DW-PG_W){1'b0}}, lim_q};
    end

    assign hit = |hits;

endmodule

// File: rtl/iso_err_log.sv
module iso_err_log
    import iso_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             h_err,
    input  logic [IG_AW-1:0] h_err_addr,
    input  logic             d_err,
    input  cause_e           d_err_cause,
    input  logic [IG_AW-1:0] d_err_addr,
    input  logic             clr,
    output stat_t            stat,
    output logic [IG_AW-1:0] err_addr
);

    stat_t            stat_q;
    logic [IG_AW-1:0] addr_q;
    logic             any_err;

    assign any_err = h_err || d_err;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            addr_q <= '0;
        end else if (any_err) begin
            if (stat_q.frozen && !clr) begin
                stat_q.ovf <= 1'b1;
            end else begin
                stat_q.frozen <= 1'b1;
                stat_q.cause  <= h_err ? CAUSE_PARITY : d_err_cause;
                stat_q.ovf    <= h_err && d_err;
                addr_q        <= h_err ? h_err_addr : d_err_addr;
            end
        end else if (clr) begin
            stat_q <= '0;
            addr_q <= '0;
        end
    end

    assign stat     = stat_q;
    assign err_addr = addr_q;

    // R10
    keep_first_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_q.frozen && !clr) |=> ($stable(addr_q) && $stable(stat_q.cause) && stat_q.frozen));

    // R10
    ovf_set_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_q.frozen && !clr && any_err) |=> stat_q.ovf);

    // R9
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr && !any_err) |=> (stat_q == '0));

endmodule

// File: rtl/iso_host_fsm.sv
module iso_host_fsm
    import iso_pkg::*;
#(
    parameter int N_WIN     = 4,
    parameter int PAGE_BITS = 12,
    localparam int PG_W     = IG_AW - PAGE_BITS,
    localparam int IDX_W    = (N_WIN > 1) ? $clog2(N_WIN) : 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        h_req_valid,
    output logic                        h_req_ready,
    input  logic                        h_req_write,
    input  logic [IG_AW-1:0]            h_req_addr,
    input  logic [IG_DW-1:0]            h_req_wdata,
    input  logic                        h_req_wpar,
    output logic                        h_rsp_valid,
    input  logic                        h_rsp_ready,
    output logic [IG_DW-1:0]            h_rsp_rdata,
    output logic                        d_req_valid,
    input  logic                        d_req_ready,
    output logic                        d_req_write,
    output logic [IG_AW-1:0]            d_req_addr,
    output logic [IG_DW-1:0]            d_req_wdata,
    input  logic                        d_rsp_valid,
    output logic                        d_rsp_ready,
    input  logic [IG_DW-1:0]            d_rsp_rdata,
    input  logic                        d_rsp_rpar,
    input  stat_t                       stat_i,
    input  logic [IG_AW-1:0]            err_addr_i,
    input  logic [N_WIN-1:0][IG_DW-1:0] rd_base_i,
    input  logic [N_WIN-1:0][IG_DW-1:0] rd_lim_i,
    output logic                        h_err,
    output logic [IG_AW-1:0]            h_err_addr,
    output logic                        clr,
    output logic                        win_we,
    output logic [IDX_W-1:0]            win_idx,
    output logic                        win_is_lim,
    output logic                        win_wvld,
    output logic [PG_W-1:0]             win_wpage
);

    localparam logic [5:0] WIN_SPAN = 6'(2 * N_WIN);

    host_st_e         st_q;
    hreq_t            req_q;
    logic [IG_DW-1:0] rsp_q;

    logic             acc;
    logic             is_local;
    logic             wpar_bad;
    logic             rsp_par_bad;
    logic             frozen;
    logic [5:0]       loc_off;
    logic [5:0]       win_rel;
    logic             loc_wr;
    logic [IG_DW-1:0] lrd;

    assign frozen      = stat_i.frozen;
    assign h_req_ready = (st_q == HS_IDLE);
    assign acc         = h_req_valid && h_req_ready;
    assign is_local    = (h_req_addr[IG_AW-1:IG_AW-4] == LOCAL_TAG);
    assign wpar_bad    = h_req_write && par_bad(h_req_wdata, h_req_wpar);
    assign loc_off     = h_req_addr[7:2];
    assign win_rel     = loc_off - OFF_WIN;
    assign loc_wr      = acc && is_local && h_req_write && !wpar_bad;
    assign rsp_par_bad = (st_q == HS_DEVRSP) && d_rsp_valid && !req_q.write
                         && par_bad(d_rsp_rdata, d_rsp_rpar);

    // Error and register-write strobes toward the neighbours
    assign h_err      = (acc && wpar_bad) || rsp_par_bad;
    assign h_err_addr = (st_q == HS_DEVRSP) ? req_q.addr : h_req_addr;
    assign clr        = loc_wr && (loc_off == OFF_CTRL) && h_req_wdata[0];
    assign win_we     = loc_wr && (loc_off >= OFF_WIN) && (win_rel < WIN_SPAN);
    assign win_idx    = win_rel[IDX_W:1];
    assign win_is_lim = win_rel[0];
    assign win_wvld   = h_req_wdata[IG_DW-1];
    assign win_wpage  = h_req_wdata[PG_W-1:0];

    // Local register read mux
    always_comb begin
        lrd = '0;
        if (loc_off == OFF_STAT) begin
            lrd = {{(IG_DW-$bits(stat_t)){1'b0}}, stat_i};
        end else if (loc_off == OFF_EADDR) begin
            lrd = err_addr_i;
        end
        for (int i = 0; i < N_WIN; i++) begin
            if (loc_off == OFF_WIN + 6'(2 * i)) begin
                lrd = rd_base_i[i];
            end
            if (loc_off == OFF_WIN + 6'(2 * i + 1)) begin
                lrd = rd_lim_i[i];
            end
        end
    end

    assign d_req_valid = (st_q == HS_DEVREQ) && !frozen;
    assign d_req_write = req_q.write;
    assign d_req_addr  = req_q.addr;
    assign d_req_wdata = req_q.data;
    assign d_rsp_ready = (st_q == HS_DEVRSP);
    assign h_rsp_valid = (st_q == HS_RESP);
    assign h_rsp_rdata = rsp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= HS_IDLE;
            req_q <= '0;
            rsp_q <= '0;
        end else begin
            unique case (st_q)
                HS_IDLE: begin
                    if (acc) begin
                        req_q <= '{write: h_req_write, addr: h_req_addr, data: h_req_wdata};
                        if (is_local) begin
                            rsp_q <= h_req_write ? '0 : lrd;
                            st_q  <= HS_RESP;
                        end else if (frozen || wpar_bad) begin
                            rsp_q <= h_req_write ? '0 : ALL_ONES;
                            st_q  <= HS_RESP;
                        end else begin
                            st_q <= HS_DEVREQ;
                        end
                    end
                end
                HS_DEVREQ: begin
                    if (frozen) begin
                        rsp_q <= req_q.write ? '0 : ALL_ONES;
                        st_q  <= HS_RESP;
                    end else if (d_req_ready) begin
                        st_q <= HS_DEVRSP;
                    end
                end
                HS_DEVRSP: begin
                    if (d_rsp_valid) begin
                        if (req_q.write) begin
                            rsp_q <= '0;
                        end else if (frozen || rsp_par_bad) begin
                            rsp_q <= ALL_ONES;
                        end else begin
                            rsp_q <= d_rsp_rdata;
                        end
                        st_q <= HS_RESP;
                    end
                end
                HS_RESP: begin
                    if (h_rsp_ready) begin
                        st_q <= HS_IDLE;
                    end
                end
                default: st_q <= HS_IDLE;
            endcase
        end
    end

    // R3
    host_par_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && wpar_bad) |=> !d_req_valid);

    // R5
    ones_chk: assert property (@(posedge clk) disable iff (rst)
        ((st_q == HS_DEVRSP) && d_rsp_valid && !req_q.write && frozen)
        |=> (h_rsp_valid && h_rsp_rdata == ALL_ONES));

    // R6
    drop_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && !is_local && frozen) |=> (!d_req_valid && h_rsp_valid));

    // R11
    rsp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (h_rsp_valid && !h_rsp_ready) |=> (h_rsp_valid && $stable(h_rsp_rdata)));

endmodule

// File: rtl/iso_gate.sv
module iso_gate
    import iso_pkg::*;
#(
    parameter int N_WIN     = 4,
    parameter int PAGE_BITS = 12,
    localparam int PG_W     = IG_AW - PAGE_BITS,
    localparam int IDX_W    = (N_WIN > 1) ? $clog2(N_WIN) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             h_req_valid,
    output logic             h_req_ready,
    input  logic             h_req_write,
    input  logic [IG_AW-1:0] h_req_addr,
    input  logic [IG_DW-1:0] h_req_wdata,
    input  logic             h_req_wpar,
    output logic             h_rsp_valid,
    input  logic             h_rsp_ready,
    output logic [IG_DW-1:0] h_rsp_rdata,
    output logic             d_req_valid,
    input  logic             d_req_ready,
    output logic             d_req_write,
    output logic [IG_AW-1:0] d_req_addr,
    output logic [IG_DW-1:0] d_req_wdata,
    input  logic             d_rsp_valid,
    output logic             d_rsp_ready,
    input  logic [IG_DW-1:0] d_rsp_rdata,
    input  logic             d_rsp_rpar,
    input  logic             dma_valid,
    output logic             dma_ready,
    input  logic [IG_AW-1:0] dma_addr,
    input  logic [IG_DW-1:0] dma_data,
    input  logic             dma_par,
    output logic             mem_valid,
    input  logic             mem_ready,
    output logic [IG_AW-1:0] mem_addr,
    output logic [IG_DW-1:0] mem_data
);

    stat_t                       stat;
    logic [IG_AW-1:0]            err_addr;
    logic [N_WIN-1:0][IG_DW-1:0] rd_base;
    logic [N_WIN-1:0][IG_DW-1:0] rd_lim;
    logic                        h_err;
    logic [IG_AW-1:0]            h_err_addr;
    logic                        clr;
    logic                        win_we;
    logic [IDX_W-1:0]            win_idx;
    logic                        win_is_lim;
    logic                        win_wvld;
    logic [PG_W-1:0]             win_wpage;
    logic                        win_hit;
    logic                        dma_bad;
    logic                        d_err;
    cause_e                      d_cause;

    iso_host_fsm #(.N_WIN(N_WIN), .PAGE_BITS(PAGE_BITS)) u_host (
        .clk         (clk),
        .rst         (rst),
        .h_req_valid (h_req_valid),
        .h_req_ready (h_req_ready),
        .h_req_write (h_req_write),
        .h_req_addr  (h_req_addr),
        .h_req_wdata (h_req_wdata),
        .h_req_wpar  (h_req_wpar),
        .h_rsp_valid (h_rsp_valid),
        .h_rsp_ready (h_rsp_ready),
        .h_rsp_rdata (h_rsp_rdata),
        .d_req_valid (d_req_valid),
        .d_req_ready (d_req_ready),
        .d_req_write (d_req_write),
        .d_req_addr  (d_req_addr),
        .d_req_wdata (d_req_wdata),
        .d_rsp_valid (d_rsp_valid),
        .d_rsp_ready (d_rsp_ready),
        .d_rsp_rdata (d_rsp_rdata),
        .d_rsp_rpar  (d_rsp_rpar),
        .stat_i      (stat),
        .err_addr_i  (err_addr),
        .rd_base_i   (rd_base),
        .rd_lim_i    (rd_lim),
        .h_err       (h_err),
        .h_err_addr  (h_err_addr),
        .clr         (clr),
        .win_we      (win_we),
        .win_idx     (win_idx),
        .win_is_lim  (win_is_lim),
        .win_wvld    (win_wvld),
        .win_wpage   (win_wpage)
    );

    iso_win_table #(.N_WIN(N_WIN), .PAGE_BITS(PAGE_BITS)) u_win (
        .clk      (clk),
        .rst      (rst),
        .we       (win_we),
        .idx      (win_idx),
        .is_lim   (win_is_lim),
        .wvld     (win_wvld),
        .wpage    (win_wpage),
        .chk_page (dma_addr[IG_AW-1:PAGE_BITS]),
        .hit      (win_hit),
        .rd_base  (rd_base),
        .rd_lim   (rd_lim)
    );

    iso_err_log u_log (
        .clk         (clk),
        .rst         (rst),
        .h_err       (h_err),
        .h_err_addr  (h_err_addr),
        .d_err       (d_err),
        .d_err_cause (d_cause),
        .d_err_addr  (dma_addr),
        .clr         (clr),
        .stat        (stat),
        .err_addr    (err_addr)
    );

    // DMA gate: bad requests and everything while frozen are consumed here
    assign dma_bad   = !win_hit || par_bad(dma_data, dma_par);
    assign d_err     = dma_valid && dma_bad;
    assign d_cause   = win_hit ? CAUSE_PARITY : CAUSE_UNMAPPED;
    assign mem_valid = dma_valid && !stat.frozen && !dma_bad;
    assign dma_ready = (stat.frozen || dma_bad) ? 1'b1 : mem_ready;
    assign mem_addr  = dma_addr;
    assign mem_data  = dma_data;

    // R7
    dma_block_chk: assert property (@(posedge clk) disable iff (rst)
        d_err |=> !mem_valid);

    // R4
    dma_pass_chk: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> (win_hit && !par_bad(mem_data, dma_par)));

endmodule

// File: tb/iso_gate_bench.sv
module iso_gate_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        h_req_valid = 1'b0;
    logic        h_req_ready;
    logic        h_req_write = 1'b0;
    logic [31:0] h_req_addr = '0;
    logic [31:0] h_req_wdata = '0;
    logic        h_req_wpar = 1'b0;
    logic        h_rsp_valid;
    logic        h_rsp_ready = 1'b0;
    logic [31:0] h_rsp_rdata;
    logic        d_req_valid;
    logic        d_req_ready;
    logic        d_req_write;
    logic [31:0] d_req_addr;
    logic [31:0] d_req_wdata;
    logic        d_rsp_valid;
    logic        d_rsp_ready;
    logic [31:0] d_rsp_rdata;
    logic        d_rsp_rpar;
    logic        dma_valid = 1'b0;
    logic        dma_ready;
    logic [31:0] dma_addr = '0;
    logic [31:0] dma_data = '0;
    logic        dma_par = 1'b0;
    logic        mem_valid;
    logic        mem_ready;
    logic [31:0] mem_addr;
    logic [31:0] mem_data;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    iso_gate u_iso_gate (.*);

    // Device model: always ready, answers one cycle after a request
    logic        dev_corrupt = 1'b0;
    int          dev_cnt = 0;
    logic [31:0] dev_last_addr = '0;
    logic [31:0] dev_last_wdata = '0;

    assign d_req_ready = 1'b1;
    assign mem_ready   = 1'b1;

    function automatic logic [31:0] dev_data(input logic [31:0] a);
        return a ^ 32'h5A5A_0000;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            d_rsp_valid <= 1'b0;
            d_rsp_rdata <= '0;
            d_rsp_rpar  <= 1'b0;
        end else if (d_req_valid && d_req_ready) begin
            dev_cnt       <= dev_cnt + 1;
            dev_last_addr <= d_req_addr;
            if (d_req_write) dev_last_wdata <= d_req_wdata;
            d_rsp_valid <= 1'b1;
            d_rsp_rdata <= d_req_write ? 32'h0 : dev_data(d_req_addr);
            d_rsp_rpar  <= (^(d_req_write ? 32'h0 : dev_data(d_req_addr))) ^ dev_corrupt;
        end else if (d_rsp_valid && d_rsp_ready) begin
            d_rsp_valid <= 1'b0;
        end
    end

    // Memory model
    int          mem_cnt = 0;
    logic [31:0] mem_last_addr = '0;
    always @(posedge clk) begin
        if (!rst && mem_valid && mem_ready) begin
            mem_cnt       <= mem_cnt + 1;
            mem_last_addr <= mem_addr;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic host_xfer(input bit we, input logic [31:0] addr, input logic [31:0] data,
                             input bit badpar, input int hold, output logic [31:0] rd,
                             output int hold_bad);
        hold_bad = 0;
        @(negedge clk);
        h_req_valid = 1'b1;
        h_req_write = we;
        h_req_addr  = addr;
        h_req_wdata = data;
        h_req_wpar  = (^data) ^ badpar;
        while (!h_req_ready) @(negedge clk);
        @(negedge clk);
        h_req_valid = 1'b0;
        while (!h_rsp_valid) @(negedge clk);
        rd = h_rsp_rdata;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            if (!h_rsp_valid || h_rsp_rdata !== rd) hold_bad++;
        end
        h_rsp_ready = 1'b1;
        @(negedge clk);
        h_rsp_ready = 1'b0;
    endtask

    task automatic hwr(input logic [31:0] addr, input logic [31:0] data);
        logic [31:0] rd;
        int hb;
        host_xfer(1'b1, addr, data, 1'b0, 0, rd, hb);
    endtask

    task automatic hrd(input logic [31:0] addr, output logic [31:0] rd);
        int hb;
        host_xfer(1'b0, addr, 32'h0, 1'b0, 0, rd, hb);
    endtask

    task automatic dma_xfer(input logic [31:0] addr, input logic [31:0] data, input bit badpar);
        @(negedge clk);
        dma_valid = 1'b1;
        dma_addr  = addr;
        dma_data  = data;
        dma_par   = (^data) ^ badpar;
        while (!dma_ready) @(negedge clk);
        @(negedge clk);
        dma_valid = 1'b0;
    endtask

    task automatic check_status(input logic [31:0] exp_st, input logic [31:0] exp_addr, input string req);
        logic [31:0] rd;
        hrd(32'hF000_0000, rd);
        chk(rd == exp_st, req, rd, exp_st);
        hrd(32'hF000_0004, rd);
        chk(rd == exp_addr, req, rd, exp_addr);
    endtask

    task automatic do_clear();
        hwr(32'hF000_0008, 32'h1);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!h_rsp_valid && !d_req_valid && !mem_valid && h_req_ready, "R1 idle outputs",
            {28'h0, h_rsp_valid, d_req_valid, mem_valid, h_req_ready}, 32'h1);
        check_status(32'h0, 32'h0, "R1 status after reset");
    endtask

    task automatic t_program();
        logic [31:0] rd;
        hwr(32'hF000_0010, 32'h8000_0010);
        hwr(32'hF000_0014, 32'h0000_0013);
        hwr(32'hF000_0018, 32'h0000_0020);
        hwr(32'hF000_001C, 32'h0000_0020);
        hrd(32'hF000_0010, rd);
        chk(rd == 32'h8000_0010, "R12 base readback", rd, 32'h8000_0010);
        hrd(32'hF000_0014, rd);
        chk(rd == 32'h0000_0013, "R8 limit readback", rd, 32'h0000_0013);
    endtask

    task automatic t_forward();
        logic [31:0] rd;
        int c0 = dev_cnt;
        hrd(32'h0000_1234, rd);
        chk(rd == dev_data(32'h0000_1234), "R2 forwarded read data", rd, dev_data(32'h0000_1234));
        hwr(32'h0000_0040, 32'hDEAD_BEEF);
        chk(dev_cnt == c0 + 2, "R2 device request count", dev_cnt, c0 + 2);
        chk(dev_last_wdata == 32'hDEAD_BEEF, "R2 forwarded write data", dev_last_wdata, 32'hDEAD_BEEF);
    endtask

    task automatic t_dma_ok();
        int m0 = mem_cnt;
        dma_xfer(32'h0001_0FFC, 32'h1111_2222, 1'b0);
        dma_xfer(32'h0001_3008, 32'h3333_4444, 1'b0);
        chk(mem_cnt == m0 + 2, "R12 mapped DMA incl. limit page", mem_cnt, m0 + 2);
        chk(mem_last_addr == 32'h0001_3008, "R4 mapped DMA address", mem_last_addr, 32'h0001_3008);
    endtask

    task automatic t_host_par();
        logic [31:0] rd;
        int hb;
        int c0 = dev_cnt;
        host_xfer(1'b1, 32'h0000_0080, 32'h0F0F_0001, 1'b1, 0, rd, hb);
        chk(dev_cnt == c0, "R3 bad-parity write not forwarded", dev_cnt, c0);
        chk(rd == 32'h0, "R3 bad-parity write acked", rd, 32'h0);
        check_status(32'h1, 32'h0000_0080, "R3 R8 status after host parity error");
    endtask

    task automatic t_frozen();
        logic [31:0] rd;
        int c0 = dev_cnt;
        int m0 = mem_cnt;
        hrd(32'h0000_1234, rd);
        chk(rd == 32'hFFFF_FFFF, "R5 frozen read all ones", rd, 32'hFFFF_FFFF);
        hwr(32'h0000_0044, 32'h1234_5678);
        chk(dev_cnt == c0, "R5 R6 no device access while frozen", dev_cnt, c0);
        dma_xfer(32'h0001_0000, 32'h5555_6666, 1'b0);
        chk(mem_cnt == m0, "R7 frozen DMA blocked", mem_cnt, m0);
    endtask

    task automatic t_overflow();
        dma_xfer(32'h0003_0000, 32'h0, 1'b0);
        check_status(32'h5, 32'h0000_0080, "R10 first error kept, overflow set");
    endtask

    task automatic t_clear();
        logic [31:0] rd;
        int c0;
        do_clear();
        check_status(32'h0, 32'h0, "R9 status cleared");
        c0 = dev_cnt;
        hrd(32'h0000_0500, rd);
        chk(rd == dev_data(32'h0000_0500) && dev_cnt == c0 + 1, "R9 forwarding resumes",
            rd, dev_data(32'h0000_0500));
    endtask

    task automatic t_unmapped();
        int m0 = mem_cnt;
        dma_xfer(32'h0002_0004, 32'hABCD_0000, 1'b0);
        chk(mem_cnt == m0, "R4 R12 DMA to disabled window not passed", mem_cnt, m0);
        check_status(32'h3, 32'h0002_0004, "R4 unmapped cause and address");
        do_clear();
    endtask

    task automatic t_dma_par();
        int m0 = mem_cnt;
        dma_xfer(32'h0001_1000, 32'h0000_0007, 1'b1);
        chk(mem_cnt == m0, "R3 bad-parity DMA not passed", mem_cnt, m0);
        check_status(32'h1, 32'h0001_1000, "R3 DMA parity cause");
        do_clear();
    endtask

    task automatic t_dev_par();
        logic [31:0] rd;
        dev_corrupt = 1'b1;
        hrd(32'h0000_0200, rd);
        dev_corrupt = 1'b0;
        chk(rd == 32'hFFFF_FFFF, "R3 device parity read returns ones", rd, 32'hFFFF_FFFF);
        check_status(32'h1, 32'h0000_0200, "R3 device parity recorded");
        do_clear();
    endtask

    task automatic t_hold();
        logic [31:0] rd;
        int hb;
        host_xfer(1'b0, 32'h0000_0300, 32'h0, 1'b0, 3, rd, hb);
        chk(hb == 0, "R11 response held while not ready", hb, 0);
        chk(rd == dev_data(32'h0000_0300), "R11 held response data", rd, dev_data(32'h0000_0300));
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_program();
        t_forward();
        t_dma_ok();
        t_host_par();
        t_frozen();
        t_overflow();
        t_clear();
        t_unmapped();
        t_dma_par();
        t_dev_par();
        t_hold();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule